// File: doc/BRIEF.md
# Serial Bus Pause Controller

This block sits between the pins of a serial peripheral slave and its protocol engine. It lets the bus master stop a transfer partway through a sequence and later carry on without losing its place. The block samples the select, pause and serial clock lines on the system clock and keeps one state bit that says whether the transfer is paused. From that bit it gates the qualified serial clock edge strobes that drive the engine's shift register and bit counter. It also freezes the captured serial input bit and removes the output enable of the serial data driver.

The pause and resume decisions are tied to the level of the serial clock. A pause request made while the clock is low takes effect at once. A request made while the clock is high waits for the clock to fall. Release follows the same rule. The select line is never gated. Deselecting the slave clears the pause and drops any pause request that is still waiting.

Top module: `hold_pause_ctrl`

## Requirements
- R1: After a synchronous reset, `hold_active`, `sck_rise_en`, `sck_fall_en` and `si_smp` are 0. `so_oe` stays 0 while `cs_n` is high.
- R2: When `cs_n` is low, `hold_n` is low and `sck` is low in a sampled cycle, `hold_active` is 1 from the next clock edge.
- R3: When `hold_n` goes low while `sck` is high, `hold_active` stays 0 while `sck` stays high. The cycle in which `sck` is first sampled low produces no `sck_fall_en`, and `hold_active` is 1 from the next edge.
- R4: A paused transfer is released only in a cycle where `hold_n` is high and `sck` is low. Raising `hold_n` while `sck` is high keeps `hold_active` at 1 until `sck` is sampled low.
- R5: While `hold_active` is 1, `sck_rise_en` and `sck_fall_en` stay 0 whatever `sck` does, and `si_smp` does not change whatever `si` does.
- R6: `so_oe` is 0 in the same cycle that `hold_n` is sampled low, with no register in between. It stays 0 for as long as `hold_active` is 1 or `cs_n` is high.
- R7: A sampled high `cs_n` makes `hold_active` 0 on the next edge, and any pause request that is still waiting is dropped.
- R8: After release, the next qualified rising edge delivers the next bit of the interrupted sequence. No edge strobe is made for clock movement that happened during the pause, so a byte split by a pause is captured intact.
- R9: With `cs_n` low and not paused, a sampled 0-to-1 change of `sck` gives a one-cycle `sck_rise_en` and a sampled 1-to-0 change gives a one-cycle `sck_fall_en`. The `si` value of a rising cycle appears on `si_smp` after the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Slave select, active low, already synchronized |
| hold_n | input | 1 | Pause request, active low, already synchronized |
| sck | input | 1 | Serial clock level, already synchronized |
| si | input | 1 | Serial data input level |
| hold_active | output | 1 | Transfer is paused |
| sck_rise_en | output | 1 | Qualified rising serial clock strobe for the engine |
| sck_fall_en | output | 1 | Qualified falling serial clock strobe for the engine |
| si_smp | output | 1 | Serial input bit captured on the last qualified rise |
| so_oe | output | 1 | Output enable for the serial data driver |

## Verification
The bench goes after the level rules at the edges of a pause. A pause requested with the clock high must wait for the falling edge and must swallow that edge. A design that acted on the request at once, or let the edge through, would shift the output one bit early. A release attempted with the clock high must not take effect. If it did, the engine would see a phantom rising edge when the clock next moves. The bench also splits a byte with a pause that toggles the clock and input, so a design that leaked an edge or a bit shows up as a corrupted byte. Deselecting during a pending request checks that no stale pause survives into the next sequence.

// File: rtl/hold_pkg.sv
package hold_pkg;

    typedef enum logic {
        HP_RUN   = 1'b0,
        HP_PAUSE = 1'b1
    } hp_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } sck_edge_t;

    // Pause decisions are only made while the serial clock is low;
    // with the clock high the current state is kept.
    function automatic hp_state_e hp_next(hp_state_e cur, logic cs_n,
                                          logic hold_n, logic sck);
        if (cs_n) begin
            return HP_RUN;
        end
        if (sck) begin
            return cur;
        end
        return hold_n ? HP_RUN : HP_PAUSE;
    endfunction

endpackage

// File: rtl/hp_edge.sv
module hp_edge
    import hold_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sck,
    output sck_edge_t raw
);
    logic sck_q;

    // Tracks the clock even during a pause so release sees no stale edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
        end else begin
            sck_q <= sck;
        end
    end

    always_comb begin
        raw.rise = sck & ~sck_q;
        raw.fall = ~sck & sck_q;
    end
endmodule

// File: rtl/hp_fsm.sv
module hp_fsm
    import hold_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cs_n,
    input  logic      hold_n,
    input  logic      sck,
    output hp_state_e state,
    output hp_state_e nxt
);
    always_comb begin
        nxt = hp_next(state, cs_n, hold_n, sck);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= HP_RUN;
        end else begin
            state <= nxt;
        end
    end
endmodule

// File: rtl/hp_gate.sv
module hp_gate
    import hold_pkg::*;
#(
    parameter logic SI_INIT = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cs_n,
    input  logic      hold_n,
    input  logic      si,
    input  hp_state_e state,
    input  hp_state_e nxt,
    input  sck_edge_t raw,
    output logic      rise_en,
    output logic      fall_en,
    output logic      si_smp,
    output logic      so_oe
);
    logic mask;

    // The edge that enters a pause is swallowed, as is every edge inside it.
    always_comb begin
        mask    = cs_n | (state == HP_PAUSE) | (nxt == HP_PAUSE);
        rise_en = raw.rise & ~mask;
        fall_en = raw.fall & ~mask;
        so_oe   = ~cs_n & hold_n & (state == HP_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            si_smp <= SI_INIT;
        end else if (rise_en) begin
            si_smp <= si;
        end
    end
endmodule

// File: rtl/hold_pause_ctrl.sv
module hold_pause_ctrl
    import hold_pkg::*;
#(
    parameter logic SI_INIT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic hold_n,
    input  logic sck,
    input  logic si,
    output logic hold_active,
    output logic sck_rise_en,
    output logic sck_fall_en,
    output logic si_smp,
    output logic so_oe
);
    sck_edge_t raw;
    hp_state_e state;
    hp_state_e nxt;

    hp_edge i_edge (
        .clk (clk),
        .rst (rst),
        .sck (sck),
        .raw (raw)
    );

    hp_fsm i_fsm (
        .clk    (clk),
        .rst    (rst),
        .cs_n   (cs_n),
        .hold_n (hold_n),
        .sck    (sck),
        .state  (state),
        .nxt    (nxt)
    );

    hp_gate #(.SI_INIT(SI_INIT)) i_gate (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .hold_n  (hold_n),
        .si      (si),
        .state   (state),
        .nxt     (nxt),
        .raw     (raw),
        .rise_en (sck_rise_en),
        .fall_en (sck_fall_en),
        .si_smp  (si_smp),
        .so_oe   (so_oe)
    );

    assign hold_active = (state == HP_PAUSE);
endmodule

// File: rtl/hp_checker.sv
module hp_checker (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic hold_n,
    input logic sck,
    input logic hold_active,
    input logic sck_rise_en,
    input logic sck_fall_en,
    input logic si_smp,
    input logic so_oe
);
    p_enter_low_r2: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !hold_n && !sck) |=> hold_active);

    p_defer_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (!hold_active && sck) |=> !hold_active);

    p_defer_exit_r4: assert property (@(posedge clk) disable iff (rst)
        (hold_active && !cs_n && sck) |=> hold_active);

    p_no_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        hold_active |-> (!sck_rise_en && !sck_fall_en));

    p_si_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        hold_active |=> $stable(si_smp));

    p_oe_off_r6: assert property (@(posedge clk) disable iff (rst)
        (hold_active || !hold_n || cs_n) |-> !so_oe);

    p_cs_clear_r7: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !hold_active);

    p_strobe_cs_r9: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (!sck_rise_en && !sck_fall_en));
endmodule

bind hold_pause_ctrl hp_checker i_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .hold_n      (hold_n),
    .sck         (sck),
    .hold_active (hold_active),
    .sck_rise_en (sck_rise_en),
    .sck_fall_en (sck_fall_en),
    .si_smp      (si_smp),
    .so_oe       (so_oe)
);

// File: tb/test_hold_pause_ctrl.sv
`timescale 1ns/1ps
module test_hold_pause_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, hold_n = 1'b1, sck = 1'b0, si = 1'b0;
    logic hold_active, sck_rise_en, sck_fall_en, si_smp, so_oe;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    hold_pause_ctrl i_hold_pause_ctrl (
        .clk(clk), .rst(rst), .cs_n(cs_n), .hold_n(hold_n), .sck(sck), .si(si),
        .hold_active(hold_active), .sck_rise_en(sck_rise_en),
        .sck_fall_en(sck_fall_en), .si_smp(si_smp), .so_oe(so_oe)
    );

    typedef struct {
        logic hold;
        logic rise;
        logic fall;
        logic oe;
        logic smp;
        string tag;
    } exp_t;

    exp_t  sb[$];
    string cur_tag = "R9";

    // reference state, derived from the requirements
    logic m_hold = 1'b0, m_sckq = 1'b0, m_smp = 1'b0;
    logic rose_prev = 1'b0;
    logic [7:0] obs_byte = 8'h00;

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic h, input logic s, input logic d);
        exp_t e;
        logic nh;
        logic blk;
        @(negedge clk);
        cs_n = c; hold_n = h; sck = s; si = d;
        // pause state follows the pause pin only while the clock is low
        if (c) nh = 1'b0;
        else if (s) nh = m_hold;
        else nh = ~h;
        blk    = c | m_hold | nh;
        e.hold = m_hold;
        e.rise = s & ~m_sckq & ~blk;
        e.fall = ~s & m_sckq & ~blk;
        e.oe   = ~c & h & ~m_hold;
        e.smp  = m_smp;
        e.tag  = cur_tag;
        sb.push_back(e);
        if (e.rise) m_smp = d;
        m_hold = nh;
        m_sckq = s;
        #6;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        #5;
        if (rose_prev) obs_byte = {obs_byte[6:0], si_smp};
        rose_prev = sck_rise_en;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(hold_active === e.hold, e.tag, "hold_active", hold_active, e.hold);
            check(sck_rise_en === e.rise, e.tag, "sck_rise_en", sck_rise_en, e.rise);
            check(sck_fall_en === e.fall, e.tag, "sck_fall_en", sck_fall_en, e.fall);
            check(so_oe === e.oe, e.tag, "so_oe", so_oe, e.oe);
            check(si_smp === e.smp, e.tag, "si_smp", si_smp, e.smp);
        end
    end

    task automatic send_bit(input logic b);
        step(1'b0, 1'b1, 1'b0, b);
        step(1'b0, 1'b1, 1'b1, b);
    endtask

    initial begin
        #100000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic held_smp;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #6;
        // R1: reset state
        check(hold_active === 1'b0, "R1", "hold_active", hold_active, 0);
        check(so_oe === 1'b0, "R1", "so_oe", so_oe, 0);
        check(si_smp === 1'b0, "R1", "si_smp", si_smp, 0);

        // R9: plain edges
        cur_tag = "R9";
        step(1'b0, 1'b1, 1'b0, 1'b1);
        check(so_oe === 1'b1, "R9", "so_oe selected", so_oe, 1);
        send_bit(1'b1);
        check(sck_rise_en === 1'b1, "R9", "rise strobe", sck_rise_en, 1);
        send_bit(1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        check(sck_fall_en === 1'b1, "R9", "fall strobe", sck_fall_en, 1);

        // R2, R6: enter with clock low
        cur_tag = "R2";
        step(1'b0, 1'b0, 1'b0, 1'b0);
        check(so_oe === 1'b0, "R6", "so_oe same cycle", so_oe, 0);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        check(hold_active === 1'b1, "R2", "hold_active", hold_active, 1);

        // R5: activity during pause
        cur_tag = "R5";
        held_smp = si_smp;
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b0, 1'b1, ~held_smp);
            step(1'b0, 1'b0, 1'b0, ~held_smp);
        end
        #4;
        check(si_smp === held_smp, "R5", "si_smp frozen", si_smp, held_smp);

        // R4: release attempt with clock high
        cur_tag = "R4";
        step(1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b1, 1'b0);
        check(hold_active === 1'b1, "R4", "still paused", hold_active, 1);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        check(sck_fall_en === 1'b0, "R4", "no fall on release", sck_fall_en, 0);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        check(hold_active === 1'b0, "R4", "released", hold_active, 0);

        // R3: request with clock high waits for fall
        cur_tag = "R3";
        step(1'b0, 1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        check(so_oe === 1'b0, "R6", "so_oe off at request", so_oe, 0);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        check(hold_active === 1'b0, "R3", "deferred", hold_active, 0);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        check(sck_fall_en === 1'b0, "R3", "fall swallowed", sck_fall_en, 0);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        check(hold_active === 1'b1, "R3", "entered", hold_active, 1);

        // R7: deselect clears pause
        cur_tag = "R7";
        step(1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        check(hold_active === 1'b0, "R7", "cleared", hold_active, 0);
        check(so_oe === 1'b0, "R6", "so_oe deselected", so_oe, 0);
        // pending request dropped by deselect
        step(1'b0, 1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        check(hold_active === 1'b0, "R7", "pending dropped", hold_active, 0);

        // R8: byte split by a noisy pause
        cur_tag = "R8";
        step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        for (int i = 7; i >= 4; i--) send_bit(8'hA5 >> i);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b0, 1'b1, 1'b1);
            step(1'b0, 1'b0, 1'b0, 1'b0);
        end
        step(1'b0, 1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        for (int i = 3; i >= 0; i--) send_bit(8'hA5 >> i);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        check(obs_byte === 8'hA5, "R8", "byte across pause", obs_byte, 8'hA5);

        step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        #20;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule